// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers five interrupt sources for a small processor core. The sources are two active-low external pins, two timer overflow events and a serial port with separate receive and transmit events. It holds one pending flag per event. A single register decides, for each external pin, whether it is sensed by level or by falling edge. Each source has its own enable bit and there is one master enable. Each source also has one priority bit, which places it in either the high or the low preemption level.

From the pending, enabled sources the controller picks one winner and presents a request together with a vector address. When the core takes the vector it pulses the acknowledge input. The acknowledge clears the winner's flag where that source's type calls for it, and marks the winner's level as in service. A return input releases the most recent level. Software can set or clear every flag through the register port, with the same effect as the hardware event.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00 and irq_req is low.
- R2: In level mode (trigger bit 0) an external flag follows the inverted pin, reaching the new value two clocks after the pin changes, even after software clears it. In edge mode (trigger bit 1) the flag is set two clocks after a high-to-low pin transition and keeps its value while the pin stays low.
- R3: A one-cycle pulse on tmr0_ovf or tmr1_ovf sets that timer flag. A pulse on ser_rx_evt or ser_tx_evt sets the receive or transmit flag. The serial source requests when either of its two flags is set.
- R4: The addresses are 0 for the control/flag register, 1 for the serial flag register, 2 for the enable register and 3 for the priority register. Control register bits: bit0 trigger of ext0, bit1 ext0 flag, bit2 trigger of ext1, bit3 ext1 flag, bit5 timer 0 flag, bit7 timer 1 flag. Serial register bits: bit0 receive, bit1 transmit. A write sets or clears the flags exactly as the hardware would.
- R5: Source indices are 0 ext0, 1 timer 0, 2 ext1, 3 timer 1, 4 serial. Enable bits 0 to 4 gate the source with the same index, and bit7 is the master enable. There is no request while the master enable or the source's own enable is clear.
- R6: Priority bit i set places source i in the high level. Any eligible high source wins over every low source. Within a level the lowest index wins. irq_vec = 0x0003 + 8 × index.
- R7: An acknowledge taken while irq_req is high clears the winner's flag if the winner is an edge-mode external source or a timer. Serial flags are never cleared by an acknowledge, and level-mode flags keep following the pin.
- R8: After a low-level source is acknowledged, only high-priority sources can raise irq_req. After a high-level source is acknowledged, none can. Each irq_ret pulse releases the high level if it is in service, and otherwise the low level.
- R9: A software write that clears a pending flag withdraws its request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_n | input | 1 | External request pin 0, active low |
| ext1_n | input | 1 | External request pin 1, active low |
| tmr0_ovf | input | 1 | Timer 0 rollover pulse |
| tmr1_ovf | input | 1 | Timer 1 rollover pulse |
| ser_rx_evt | input | 1 | Serial receive-complete pulse |
| ser_tx_evt | input | 1 | Serial transmit-complete pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address of the winner, zero when idle |
| vec_ack | input | 1 | Core has taken the vector |
| irq_ret | input | 1 | Return from the current handler |

## Verification
Several properties are checked on every cycle. A cleared master enable suppresses all requests. A high level in service blocks every request, and a low level in service admits only high-priority winners. A taken timer-0 vector clears its flag, and the serial receive flag never drops without a software write. The bench's scenarios cover the rest. They sweep every combination of pending sources against every priority mask to check the winner and vector. They also run the edge-versus-level sensing sequences with their two-cycle latency and the full nesting and return order. All of these need chosen stimulus histories that a single-cycle property cannot express.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned NSRC  = 5;
   localparam int unsigned IDX_W = $clog2(NSRC);

   localparam int unsigned SRC_EX0 = 0;
   localparam int unsigned SRC_TM0 = 1;
   localparam int unsigned SRC_EX1 = 2;
   localparam int unsigned SRC_TM1 = 3;
   localparam int unsigned SRC_SER = 4;

   typedef enum logic [1:0] {
      RA_CTL = 2'd0,
      RA_SER = 2'd1,
      RA_ENA = 2'd2,
      RA_PRI = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic hi;
      logic lo;
   } isr_t;
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic sw_we,
   input  logic sw_val,
   input  logic ack_clr,
   output logic flag
);
   logic smp_q, smp_d_q, flag_q;
   logic fall;

   assign fall = smp_d_q & ~smp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q   <= 1'b1;
         smp_d_q <= 1'b1;
         flag_q  <= 1'b0;
      end else begin
         smp_q   <= pin_n;
         smp_d_q <= smp_q;
         if (sw_we)
            flag_q <= sw_val;
         else if (!edge_mode)
            flag_q <= ~smp_q;
         else if (fall)
            flag_q <= 1'b1;
         else if (ack_clr)
            flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
   parameter bit AUTO_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic sw_we,
   input  logic sw_val,
   input  logic ack_clr,
   output logic flag
);
   logic flag_q;
   logic clr_eff;

   generate
      if (AUTO_CLR) begin : g_autoclr
         assign clr_eff = ack_clr;
      end else begin : g_keep
         logic unused_ack;
         assign unused_ack = ack_clr;
         assign clr_eff    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (sw_we)
         flag_q <= sw_val;
      else if (set_evt)
         flag_q <= 1'b1;
      else if (clr_eff)
         flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned N         = 5,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  pend,
   input  logic [N-1:0]  pri,
   input  logic          busy_hi,
   input  logic          busy_lo,
   output logic          req,
   output logic [IW-1:0] idx,
   output logic          win_hi
);
   logic [N-1:0] hi_set, lo_set, cand;

   always_comb begin
      hi_set = pend & pri;
      lo_set = pend & ~pri;
      if (busy_hi)
         cand = '0;
      else if (busy_lo || (|hi_set))
         cand = hi_set;
      else
         cand = lo_set;
   end

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (cand[i]) idx = IW'(i);
         end
      end else begin : g_msb
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (cand[i]) idx = IW'(i);
         end
      end
   endgenerate

   assign req    = |cand;
   assign win_hi = pri[idx];
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
   import irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_hi,
   input  logic ret,
   output isr_t isr
);
   isr_t isr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
      end else begin
         if (ret) begin
            if (isr_q.hi) isr_q.hi <= 1'b0;
            else          isr_q.lo <= 1'b0;
         end
         if (take) begin
            if (take_hi) isr_q.hi <= 1'b1;
            else         isr_q.lo <= 1'b1;
         end
      end
   end

   assign isr = isr_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned VEC_W     = 16,
   parameter int unsigned VEC_BASE  = 3,
   parameter int unsigned VEC_STEP  = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext0_n,
   input  logic              ext1_n,
   input  logic              tmr0_ovf,
   input  logic              tmr1_ovf,
   input  logic              ser_rx_evt,
   input  logic              ser_tx_evt,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   input  logic              vec_ack,
   input  logic              irq_ret
);
   localparam int unsigned VEC_TOP = VEC_BASE + (NSRC - 1) * VEC_STEP;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("prio_irq_ctrl: DATA_W must be at least 8");
      end
      if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
         $error("prio_irq_ctrl: VEC_W too narrow for the vector table");
      end
   endgenerate

   logic ctl_we, ser_we, ena_we, pri_we;
   assign ctl_we = reg_we && (reg_addr == RA_CTL);
   assign ser_we = reg_we && (reg_addr == RA_SER);
   assign ena_we = reg_we && (reg_addr == RA_ENA);
   assign pri_we = reg_we && (reg_addr == RA_PRI);

   logic [1:0]      trig_q;
   logic            ea_q;
   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] pri_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= '0;
         ea_q   <= 1'b0;
         en_q   <= '0;
         pri_q  <= '0;
      end else begin
         if (ctl_we) trig_q <= {reg_wdata[2], reg_wdata[0]};
         if (ena_we) begin
            ea_q <= reg_wdata[7];
            en_q <= reg_wdata[NSRC-1:0];
         end
         if (pri_we) pri_q <= reg_wdata[NSRC-1:0];
      end
   end

   logic            take;
   logic [IDX_W-1:0] win_idx;
   logic            win_hi;
   logic [NSRC-1:0] ack_oh;
   logic [1:0]      ext_flag;
   logic [1:0]      tm_flag;
   logic [1:0]      ser_flag;
   logic [1:0]      tm_evt;
   logic [1:0]      ext_pin;
   logic [1:0]      ser_evt;

   assign take    = vec_ack & irq_req;
   assign ack_oh  = take ? (NSRC'(1) << win_idx) : '0;
   assign tm_evt  = {tmr1_ovf, tmr0_ovf};
   assign ext_pin = {ext1_n, ext0_n};
   assign ser_evt = {ser_tx_evt, ser_rx_evt};

   for (genvar k = 0; k < 2; k++) begin : g_ext
      localparam int unsigned FB = 1 + 2 * k;
      localparam int unsigned SI = 2 * k;
      irq_ext_sense u_sense (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_n     (ext_pin[k]),
         .edge_mode (trig_q[k]),
         .sw_we     (ctl_we),
         .sw_val    (reg_wdata[FB]),
         .ack_clr   (ack_oh[SI]),
         .flag      (ext_flag[k])
      );
   end

   for (genvar k = 0; k < 2; k++) begin : g_tmr
      localparam int unsigned FB = 5 + 2 * k;
      localparam int unsigned SI = 2 * k + 1;
      irq_flag_cell #(.AUTO_CLR(1'b1)) u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (tm_evt[k]),
         .sw_we   (ctl_we),
         .sw_val  (reg_wdata[FB]),
         .ack_clr (ack_oh[SI]),
         .flag    (tm_flag[k])
      );
   end

   for (genvar k = 0; k < 2; k++) begin : g_ser
      irq_flag_cell #(.AUTO_CLR(1'b0)) u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (ser_evt[k]),
         .sw_we   (ser_we),
         .sw_val  (reg_wdata[k]),
         .ack_clr (ack_oh[SRC_SER]),
         .flag    (ser_flag[k])
      );
   end

   logic [NSRC-1:0] raw, pend;
   assign raw  = {|ser_flag, tm_flag[1], ext_flag[1], tm_flag[0], ext_flag[0]};
   assign pend = raw & en_q & {NSRC{ea_q}};

   isr_t isr;

   irq_arbiter #(.N(NSRC), .LSB_FIRST(LSB_FIRST)) u_arb (
      .pend    (pend),
      .pri     (pri_q),
      .busy_hi (isr.hi),
      .busy_lo (isr.lo),
      .req     (irq_req),
      .idx     (win_idx),
      .win_hi  (win_hi)
   );

   irq_level_track u_lvl (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .take_hi (win_hi),
      .ret     (irq_ret),
      .isr     (isr)
   );

   always_comb begin
      if (irq_req)
         irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(win_idx);
      else
         irq_vec = '0;
   end

   logic [7:0] rd8;
   always_comb begin
      unique case (reg_addr)
         RA_CTL:  rd8 = {tm_flag[1], 1'b0, tm_flag[0], 1'b0,
                         ext_flag[1], trig_q[1], ext_flag[0], trig_q[0]};
         RA_SER:  rd8 = {6'b0, ser_flag};
         RA_ENA:  rd8 = {ea_q, 2'b0, en_q};
         default: rd8 = {3'b0, pri_q};
      endcase
   end
   assign reg_rdata = DATA_W'(rd8);

   logic unused_bits;
   assign unused_bits = ^{reg_wdata, ack_oh[SRC_SER]};
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int unsigned NS = 5,
   parameter int unsigned IW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq_req,
   input logic          ea_q,
   input logic [NS-1:0] pri_q,
   input logic [IW-1:0] win_idx,
   input logic          isr_hi,
   input logic          isr_lo,
   input logic          take,
   input logic          ctl_we,
   input logic          ser_we,
   input logic          tmr0_ovf,
   input logic [1:0]    tm_flag,
   input logic [1:0]    ser_flag
);
   // R5
   no_req_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ea_q |-> !irq_req);

   // R8
   hi_busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isr_hi |-> !irq_req);

   // R8
   lo_busy_only_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_lo && irq_req) |-> pri_q[win_idx]);

   // R7
   tmr_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (win_idx == IW'(1)) && !tmr0_ovf && !ctl_we) |=> !tm_flag[0]);

   // R7
   ser_never_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_flag[0] && !ser_we) |=> ser_flag[0]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NS(irq_pkg::NSRC), .IW(irq_pkg::IDX_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .ea_q     (ea_q),
   .pri_q    (pri_q),
   .win_idx  (win_idx),
   .isr_hi   (isr.hi),
   .isr_lo   (isr.lo),
   .take     (take),
   .ctl_we   (ctl_we),
   .ser_we   (ser_we),
   .tmr0_ovf (tmr0_ovf),
   .tm_flag  (tm_flag),
   .ser_flag (ser_flag)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext0_n = 1'b1, ext1_n = 1'b1;
   logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
   logic        ser_rx_evt = 1'b0, ser_tx_evt = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic        vec_ack = 1'b0, irq_ret = 1'b0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ext0_n(ext0_n), .ext1_n(ext1_n),
      .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
      .ser_rx_evt(ser_rx_evt), .ser_tx_evt(ser_tx_evt),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
      .vec_ack(vec_ack), .irq_ret(irq_ret)
   );

   task automatic tick();
      @(negedge clk);
      #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_rd(input string req, input logic [1:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(req, int'(reg_rdata), int'(exp));
   endtask

   task automatic chk_irq(input string req, input logic er, input logic [15:0] ev);
      chk(req, int'(irq_req), int'(er));
      if (er) chk(req, int'(irq_vec), int'(ev));
   endtask

   task automatic ack();
      vec_ack = 1'b1; tick(); vec_ack = 1'b0;
   endtask

   task automatic ret();
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      for (int a = 0; a < 4; a++) chk_rd("R1", 2'(a), 8'h00);
      chk_irq("R1", 1'b0, 16'h0);

      // R3 / R4 hardware set events
      tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
      chk_rd("R3", 2'd0, 8'h20);
      tmr1_ovf = 1'b1; tick(); tmr1_ovf = 1'b0;
      chk_rd("R3", 2'd0, 8'hA0);
      ser_rx_evt = 1'b1; tick(); ser_rx_evt = 1'b0;
      chk_rd("R3", 2'd1, 8'h01);
      ser_tx_evt = 1'b1; tick(); ser_tx_evt = 1'b0;
      chk_rd("R3", 2'd1, 8'h03);
      // R4 software clear
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      chk_rd("R4", 2'd0, 8'h00);
      chk_rd("R4", 2'd1, 8'h00);

      // R2 level mode
      ext0_n = 1'b0; tick(); tick();
      chk_rd("R2", 2'd0, 8'h02);
      wr(2'd0, 8'h00);
      chk_rd("R2", 2'd0, 8'h00);
      tick();
      chk_rd("R2", 2'd0, 8'h02);
      ext0_n = 1'b1; tick(); tick();
      chk_rd("R2", 2'd0, 8'h00);

      // R2 edge mode
      wr(2'd0, 8'h01);
      ext0_n = 1'b0; tick(); tick();
      chk_rd("R2", 2'd0, 8'h03);
      wr(2'd0, 8'h01);
      tick(); tick();
      chk_rd("R2", 2'd0, 8'h01);
      ext0_n = 1'b1; tick(); tick();
      ext0_n = 1'b0; tick(); tick();
      chk_rd("R2", 2'd0, 8'h03);
      ext0_n = 1'b1; tick(); tick();
      wr(2'd0, 8'h00);

      // R5 enables
      wr(2'd0, 8'h20);
      wr(2'd2, 8'h02);
      chk_irq("R5", 1'b0, 16'h0);
      wr(2'd2, 8'h82);
      chk_irq("R5", 1'b1, 16'h000B);
      wr(2'd2, 8'h80);
      chk_irq("R5", 1'b0, 16'h0);

      // R6 sweep of pending patterns against priority masks
      wr(2'd2, 8'h9F);
      for (int pr = 0; pr < 32; pr++) begin
         wr(2'd3, 8'(pr));
         for (int pat = 0; pat < 32; pat++) begin
            logic [7:0] cv;
            logic [4:0] hs, s;
            int idx;
            cv = 8'h05 | (8'(pat & 1) << 1) | (8'((pat >> 1) & 1) << 5)
                 | (8'((pat >> 2) & 1) << 3) | (8'((pat >> 3) & 1) << 7);
            wr(2'd0, cv);
            wr(2'd1, ((pat >> 4) & 1) != 0 ? (((pr & 1) != 0) ? 8'h02 : 8'h01) : 8'h00);
            hs = 5'(pat & pr);
            s  = (hs != 0) ? hs : 5'(pat);
            idx = 0;
            for (int b = 4; b >= 0; b--) if (s[b]) idx = b;
            chk_irq("R6", pat != 0, 16'(3 + 8 * idx));
         end
      end

      // R7 acknowledge clearing by source type
      wr(2'd3, 8'h00); wr(2'd1, 8'h00);
      wr(2'd0, 8'h25);
      chk_irq("R7", 1'b1, 16'h000B);
      ack();
      chk_rd("R7", 2'd0, 8'h05);
      ret();
      wr(2'd0, 8'h07);
      chk_irq("R7", 1'b1, 16'h0003);
      ack();
      chk_rd("R7", 2'd0, 8'h05);
      ret();
      wr(2'd1, 8'h01);
      chk_irq("R7", 1'b1, 16'h0023);
      ack();
      chk_rd("R7", 2'd1, 8'h01);
      ret();
      chk_irq("R7", 1'b1, 16'h0023);
      wr(2'd1, 8'h00);
      // R9 cancel
      chk_irq("R9", 1'b0, 16'h0);
      wr(2'd0, 8'h01);
      ext1_n = 1'b0; tick(); tick();
      chk_rd("R7", 2'd0, 8'h09);
      chk_irq("R7", 1'b1, 16'h0013);
      ack();
      chk_rd("R7", 2'd0, 8'h09);
      ret();
      ext1_n = 1'b1; tick(); tick();
      chk_rd("R7", 2'd0, 8'h01);

      // R8 nesting
      wr(2'd0, 8'h05);
      wr(2'd3, 8'h10);
      wr(2'd0, 8'h25);
      ack();
      wr(2'd0, 8'h85);
      chk_irq("R8", 1'b0, 16'h0);
      wr(2'd1, 8'h01);
      chk_irq("R8", 1'b1, 16'h0023);
      ack();
      chk_irq("R8", 1'b0, 16'h0);
      wr(2'd1, 8'h00);
      ret();
      chk_irq("R8", 1'b0, 16'h0);
      ret();
      chk_irq("R8", 1'b1, 16'h001B);
      // R9 software clear withdraws the request
      wr(2'd0, 8'h05);
      chk_irq("R9", 1'b0, 16'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule